// File: doc/BRIEF.md
# I2C Byte Transfer Controller

This block is the byte engine of an I2C interface. Software places a byte in a one-deep holding register. When the serialiser is free, the byte moves into a shift register. The shift register drives it onto the data line most significant bit first, paced by an internally divided clock line, and a ninth clock follows as the acknowledge slot. In transmit mode the level the receiver returns in that slot is latched. An enable selects whether a negative acknowledge stops the stream of bytes or is ignored. In receive mode the block samples eight data bits and then drives a software-chosen acknowledge level.

A transmit-empty flag tells software when the holding register can take another byte. Several events set the flag. Software clears it either by reading it as 1 and then writing 0, or by writing a new byte. When a byte finishes and no new byte is waiting, the clock line stays low until data arrives or a stop is requested.

Register map on the simple bus (`bus_addr`):
- 0, data: a write loads the holding register; a read returns the last received byte.
- 1, control: bit0 transmit select, bit1 acknowledge-judge enable, bit2 acknowledge drive level, bit3 receive-go (write-only pulse).
- 2, status: bit7 transmit-empty flag, bit0 received acknowledge (read-only).

Top module: `i2c_byte_xfer`

## Requirements
- R1: After reset, the control bits (0..2), the transmit-empty flag (status bit7) and the received acknowledge (status bit0) read 0, and the clock and data outputs are high.
- R2: A transmitted byte appears on `sda_o` most significant bit first, one bit per rising edge of `scl_o`, with the ninth rising edge as the acknowledge slot.
- R3: With the judge enable (control bit1) at 0, a NACK received in the acknowledge slot is ignored and the next held byte is still sent.
- R4: With the judge enable at 1, a NACK stops transfer after that byte: the held byte is not sent, `scl_o` stays low and the flag stays clear, until `start_evt` pulses.
- R5: In transmit mode the acknowledge slot level is latched into status bit0; bus writes to that bit do not change it.
- R6: In receive mode (a control write with bit0=0 and bit3=1), eight bits are sampled from `sda_i` and returned by a data read; during the ninth clock `sda_o` equals control bit2.
- R7: The flag sets when the held byte moves into the shift register.
- R8: The flag sets when transmit select goes from 0 to 1, when `start_evt` pulses, and when `slave_tx_evt` pulses; `slave_tx_evt` also sets transmit select.
- R9: Writing 0 to status bit7 clears the flag only if a status read saw it at 1 since the last status or data write; otherwise the write, and any write of 1, leaves the flag unchanged.
- R10: A write to the data register clears the flag.
- R11: When a byte ends with the holding register empty, `scl_o` stays low and no clock pulses occur; a `stop_req` pulse returns `scl_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| start_evt | input | 1 | Start or repeated start issued |
| slave_tx_evt | input | 1 | Slave switched from receive to transmit |
| stop_req | input | 1 | Release the held clock line |
| sda_i | input | 1 | Data line level as seen on the wire |
| scl_o | output | 1 | Clock line drive (1 = released) |
| sda_o | output | 1 | Data line drive (1 = released) |

## Verification
A peer model returns a chosen ACK or NACK for each byte. The bench aims a NACK at both judge settings. A design that ignored the enable would either lose the queued byte or push it past a refusal. The bench tries a zero-write with no prior read of the flag, which a careless clear path would honour. It writes the data register while a byte is shifting, which would show a flag that never drops. It also checks the low-held clock between bytes and the driven acknowledge level in receive mode, where an off-by-one slot counter would drive the wrong bit.

// File: rtl/i2c_bx_pkg.sv
package i2c_bx_pkg;

    localparam int BYTE_BITS = 8;
    localparam int SLOT_W    = 4;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CTRL_TX_BIT    = 0;
    localparam int CTRL_JUDGE_BIT = 1;
    localparam int CTRL_ACKD_BIT  = 2;
    localparam int CTRL_GO_BIT    = 3;
    localparam int STAT_TBE_BIT   = 7;
    localparam int STAT_ACK_BIT   = 0;

    typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

    typedef struct packed {
        logic ack_drive;
        logic judge_en;
        logic tx_mode;
    } ctrl_t;

    typedef struct packed {
        logic from_load;
        logic from_txsel;
        logic from_start;
        logic from_slave;
    } tbe_set_t;

    function automatic logic any_set(input tbe_set_t s);
        return |s;
    endfunction

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.tx_mode   = b[CTRL_TX_BIT];
        c.judge_en  = b[CTRL_JUDGE_BIT];
        c.ack_drive = b[CTRL_ACKD_BIT];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        logic [7:0] b;
        b = '0;
        b[CTRL_TX_BIT]    = c.tx_mode;
        b[CTRL_JUDGE_BIT] = c.judge_en;
        b[CTRL_ACKD_BIT]  = c.ack_drive;
        return b;
    endfunction

    function automatic logic [7:0] stat_to_byte(input logic tbe, input logic ack);
        logic [7:0] b;
        b = '0;
        b[STAT_TBE_BIT] = tbe;
        b[STAT_ACK_BIT] = ack;
        return b;
    endfunction

endpackage

// File: rtl/i2c_bx_engine.sv
module i2c_bx_engine
    import i2c_bx_pkg::*;
#(
    parameter int HALF_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_byte,
    input  logic       start_tx,
    input  logic [7:0] byte_in,
    input  logic       ack_drive,
    input  logic       stop_req,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_o,
    output logic       active,
    output logic       held,
    output logic       in_ack_slot,
    output logic       byte_done,
    output logic       eng_tx,
    output logic [7:0] byte_out
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);
    localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(BYTE_BITS);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] slot;
    logic [7:0]        shreg;
    logic              tick;

    assign tick        = (cnt == CNT_LAST);
    assign in_ack_slot = active && (slot == ACK_SLOT);
    assign byte_done   = in_ack_slot && (phase == PH_HIGH) && tick;
    assign byte_out    = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_LOW;
            cnt    <= '0;
            slot   <= '0;
            shreg  <= '0;
            active <= 1'b0;
            held   <= 1'b0;
            eng_tx <= 1'b0;
        end else if (!active) begin
            if (start_byte) begin
                active <= 1'b1;
                phase  <= PH_LOW;
                cnt    <= '0;
                slot   <= '0;
                shreg  <= byte_in;
                eng_tx <= start_tx;
                held   <= 1'b0;
            end else if (stop_req) begin
                held <= 1'b0;
            end
        end else if (!tick) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
            if (phase == PH_LOW) begin
                phase <= PH_HIGH;
            end else begin
                phase <= PH_LOW;
                if (slot == ACK_SLOT) begin
                    active <= 1'b0;
                    held   <= 1'b1;
                end else begin
                    shreg <= {shreg[6:0], sda_i};
                    slot  <= slot + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (active)
            scl_o = (phase == PH_HIGH);
        else
            scl_o = !held;
    end

    always_comb begin
        sda_o = 1'b1;
        if (active) begin
            if (slot == ACK_SLOT)
                sda_o = eng_tx ? 1'b1 : ack_drive;
            else
                sda_o = eng_tx ? shreg[7] : 1'b1;
        end
    end

endmodule

// File: rtl/i2c_bx_tbe.sv
module i2c_bx_tbe
    import i2c_bx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tbe_set_t set_vec,
    input  logic     data_wr,
    input  logic     stat_rd,
    input  logic     stat_wr,
    input  logic     stat_wr_bit,
    output logic     tbe
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (stat_wr || data_wr) begin
            armed <= 1'b0;
        end else if (stat_rd && tbe) begin
            armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbe <= 1'b0;
        end else if (any_set(set_vec)) begin
            tbe <= 1'b1;
        end else if (data_wr) begin
            tbe <= 1'b0;
        end else if (stat_wr && !stat_wr_bit && armed) begin
            tbe <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_byte_xfer.sv
module i2c_byte_xfer
    import i2c_bx_pkg::*;
#(
    parameter int HALF_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       start_evt,
    input  logic       slave_tx_evt,
    input  logic       stop_req,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_o
);
    ctrl_t      ctrl_q;
    ctrl_t      ctrl_d;
    logic [7:0] hold_q;
    logic       hold_full;
    logic       halted;
    logic       ack_rx;
    logic [7:0] rx_byte;
    logic       tbe;

    logic       wr_data, wr_ctrl, wr_stat, rd_stat;
    logic       load_evt, rx_go, start_byte;
    logic       eng_active, eng_held, eng_ack_slot, byte_done, eng_tx;
    logic [7:0] byte_out;
    tbe_set_t   set_vec;

    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
    assign rd_stat = bus_rd && (bus_addr == ADDR_STAT);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl)
            ctrl_d = ctrl_from_byte(bus_wdata);
        if (slave_tx_evt)
            ctrl_d.tx_mode = 1'b1;
    end

    assign load_evt   = ctrl_q.tx_mode && hold_full && !halted && !eng_active;
    assign rx_go      = wr_ctrl && bus_wdata[CTRL_GO_BIT] && !ctrl_d.tx_mode
                        && !eng_active && !load_evt;
    assign start_byte = load_evt || rx_go;

    always_comb begin
        set_vec.from_load  = load_evt;
        set_vec.from_txsel = ctrl_d.tx_mode && !ctrl_q.tx_mode;
        set_vec.from_start = start_evt;
        set_vec.from_slave = slave_tx_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            hold_q    <= '0;
            hold_full <= 1'b0;
            halted    <= 1'b0;
            ack_rx    <= 1'b0;
            rx_byte   <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_data) begin
                hold_q    <= bus_wdata;
                hold_full <= 1'b1;
            end else if (load_evt) begin
                hold_full <= 1'b0;
            end
            if (start_evt)
                halted <= 1'b0;
            else if (byte_done && eng_tx && ctrl_q.judge_en && sda_i)
                halted <= 1'b1;
            if (byte_done && eng_tx)
                ack_rx <= sda_i;
            if (byte_done && !eng_tx)
                rx_byte <= byte_out;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_DATA: bus_rdata = rx_byte;
            ADDR_CTRL: bus_rdata = ctrl_to_byte(ctrl_q);
            ADDR_STAT: bus_rdata = stat_to_byte(tbe, ack_rx);
            default:   bus_rdata = '0;
        endcase
    end

    i2c_bx_tbe tbe_i (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (set_vec),
        .data_wr    (wr_data),
        .stat_rd    (rd_stat),
        .stat_wr    (wr_stat),
        .stat_wr_bit(bus_wdata[STAT_TBE_BIT]),
        .tbe        (tbe)
    );

    i2c_bx_engine #(.HALF_CYC(HALF_CYC)) eng_i (
        .clk        (clk),
        .rst        (rst),
        .start_byte (start_byte),
        .start_tx   (load_evt),
        .byte_in    (hold_q),
        .ack_drive  (ctrl_q.ack_drive),
        .stop_req   (stop_req),
        .sda_i      (sda_i),
        .scl_o      (scl_o),
        .sda_o      (sda_o),
        .active     (eng_active),
        .held       (eng_held),
        .in_ack_slot(eng_ack_slot),
        .byte_done  (byte_done),
        .eng_tx     (eng_tx),
        .byte_out   (byte_out)
    );

endmodule

module i2c_bx_checker
    import i2c_bx_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic wr_data,
    input logic wr_stat,
    input logic start_evt,
    input logic slave_tx_evt,
    input logic load_evt,
    input logic txsel_rise,
    input logic tbe,
    input logic ack_rx,
    input logic ack_drive,
    input logic judge_en,
    input logic tx_mode,
    input logic halted,
    input logic byte_done,
    input logic eng_tx,
    input logic eng_active,
    input logic eng_held,
    input logic eng_ack_slot,
    input logic scl_o,
    input logic sda_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!tbe && !ack_rx && !ack_drive && !judge_en && !tx_mode));

    assert_data_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !start_evt && !slave_tx_evt && !load_evt && !txsel_rise) |=> !tbe);

    assert_start_sets_R8: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> tbe);

    assert_halt_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        halted |-> !load_evt);

    assert_ackrx_readonly_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !(byte_done && eng_tx)) |=> $stable(ack_rx));

    assert_ack_drive_R6: assert property (@(posedge clk) disable iff (rst)
        (eng_ack_slot && !eng_tx) |-> (sda_o == ack_drive));

    assert_wait_low_R11: assert property (@(posedge clk) disable iff (rst)
        (eng_held && !eng_active) |-> !scl_o);
endmodule

bind i2c_byte_xfer i2c_bx_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_data     (wr_data),
    .wr_stat     (wr_stat),
    .start_evt   (start_evt),
    .slave_tx_evt(slave_tx_evt),
    .load_evt    (load_evt),
    .txsel_rise  (set_vec.from_txsel),
    .tbe         (tbe),
    .ack_rx      (ack_rx),
    .ack_drive   (ctrl_q.ack_drive),
    .judge_en    (ctrl_q.judge_en),
    .tx_mode     (ctrl_q.tx_mode),
    .halted      (halted),
    .byte_done   (byte_done),
    .eng_tx      (eng_tx),
    .eng_active  (eng_active),
    .eng_held    (eng_held),
    .eng_ack_slot(eng_ack_slot),
    .scl_o       (scl_o),
    .sda_o       (sda_o)
);

// File: tb/i2c_byte_xfer_tb.sv
module i2c_byte_xfer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       start_evt = 1'b0, slave_tx_evt = 1'b0, stop_req = 1'b0;
    logic       sda_line, scl_o, sda_o;

    int compared = 0;
    int mismatched = 0;
    bit ready = 1'b0;

    typedef struct {
        bit         is_tx;
        logic [7:0] data;
        logic       ack;
    } exp_t;
    exp_t exp_q[$];
    logic ack_q[$];

    int         rise_cnt = 0;
    int         slot = 0;
    int         byte_cnt = 0;
    logic       ack_cur = 1'b0;
    logic [7:0] cap = '0;
    logic [7:0] peer_byte = '0;
    bit         dut_tx = 1'b1;
    logic       peer_sda;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign peer_sda = dut_tx ? ((slot == 8) ? ack_cur : 1'b1)
                             : ((slot < 8) ? peer_byte[3'(7 - slot)] : 1'b1);
    assign sda_line = sda_o & peer_sda;

    i2c_byte_xfer #(.HALF_CYC(HALF)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .start_evt(start_evt), .slave_tx_evt(slave_tx_evt), .stop_req(stop_req),
        .sda_i(sda_line), .scl_o(scl_o), .sda_o(sda_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Peer model and monitor: reacts to clock line edges
    always @(scl_o) begin
        if (ready) begin
            if (scl_o === 1'b1) begin
                rise_cnt++;
                if (rise_cnt <= 8) begin
                    cap = {cap[6:0], sda_line};
                end else if (rise_cnt == 9) begin
                    byte_cnt++;
                    if (exp_q.size() == 0) begin
                        check("R2 unexpected byte", cap, 8'hxx);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (e.is_tx) check("R2 byte on wire", cap, e.data);
                        else         check("R6 driven ack level", {7'd0, sda_line}, {7'd0, e.ack});
                    end
                end
            end else if (scl_o === 1'b0) begin
                if (rise_cnt >= 9) rise_cnt = 0;
                slot = rise_cnt;
                if (slot == 8)
                    ack_cur = (ack_q.size() > 0) ? ack_q.pop_front() : 1'b0;
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_tx(input logic [7:0] d, input logic ack);
        exp_t e;
        e.is_tx = 1'b1; e.data = d; e.ack = ack;
        exp_q.push_back(e);
        ack_q.push_back(ack);
        bus_write(2'd0, d);
    endtask

    task automatic wait_bytes(input int target);
        while (byte_cnt < target) @(negedge clk);
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        ready = 1'b1;

        // R1: reset state
        bus_read(2'd2, rd); check("R1 status", rd, 8'h00);
        bus_read(2'd1, rd); check("R1 control", rd, 8'h00);
        check("R1 lines", {6'd0, scl_o, sda_o}, 8'h03);

        // R8: transmit select 0->1 sets flag
        bus_write(2'd1, 8'h01);
        bus_read(2'd2, rd); check("R8 tx select sets flag", rd & 8'h80, 8'h80);

        // R2/R7/R10: two bytes, second written while first shifts
        base = byte_cnt;
        send_tx(8'hA5, 1'b0);
        send_tx(8'h3C, 1'b0);
        bus_read(2'd2, rd); check("R10 data write clears flag", rd & 8'h80, 8'h00);
        wait_bytes(base + 2);
        bus_read(2'd2, rd); check("R7 load sets flag", rd, 8'h80);

        // R11: holding register empty -> clock held low
        base = byte_cnt;
        repeat (60) @(negedge clk);
        check("R11 scl held low", {7'd0, scl_o}, 8'h00);
        check("R11 no clocks while waiting", 8'(byte_cnt - base + rise_cnt), 8'h00);

        // R9: clear rules
        bus_write(2'd2, 8'h80);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, rd); check("R9 zero write without read ignored", rd & 8'h80, 8'h80);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, rd); check("R9 read-then-zero clears", rd & 8'h80, 8'h00);

        // R3: judge off, NACK ignored
        base = byte_cnt;
        send_tx(8'h5A, 1'b1);
        send_tx(8'hC3, 1'b0);
        wait_bytes(base + 2);
        bus_read(2'd2, rd); check("R3 continued after NACK", rd & 8'h01, 8'h00);

        // R4/R5: judge on, NACK halts
        bus_write(2'd1, 8'h03);
        base = byte_cnt;
        send_tx(8'h11, 1'b1);
        bus_write(2'd0, 8'h22);
        wait_bytes(base + 1);
        repeat (200) @(negedge clk);
        check("R4 held byte not sent", 8'(byte_cnt - base), 8'h01);
        check("R4 scl low while halted", {7'd0, scl_o}, 8'h00);
        bus_read(2'd2, rd); check("R4/R5 flag clear, NACK latched", rd, 8'h01);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, rd); check("R5 ack bit read-only", rd & 8'h01, 8'h01);
        begin
            exp_t e;
            e.is_tx = 1'b1; e.data = 8'h22; e.ack = 1'b0;
            exp_q.push_back(e);
            ack_q.push_back(1'b0);
        end
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
        bus_read(2'd2, rd); check("R8 start sets flag", rd & 8'h80, 8'h80);
        wait_bytes(base + 2);
        bus_read(2'd2, rd); check("R5 ACK latched", rd & 8'h01, 8'h00);

        // R6: receive with both acknowledge levels
        bus_write(2'd1, 8'h04);
        dut_tx = 1'b0;
        peer_byte = 8'h96;
        begin
            exp_t e;
            e.is_tx = 1'b0; e.data = 8'h96; e.ack = 1'b1;
            exp_q.push_back(e);
        end
        base = byte_cnt;
        bus_write(2'd1, 8'h0C);
        wait_bytes(base + 1);
        bus_read(2'd0, rd); check("R6 received byte", rd, 8'h96);
        peer_byte = 8'h4B;
        begin
            exp_t e;
            e.is_tx = 1'b0; e.data = 8'h4B; e.ack = 1'b0;
            exp_q.push_back(e);
        end
        bus_write(2'd1, 8'h08);
        wait_bytes(base + 2);
        bus_read(2'd0, rd); check("R6 received byte", rd, 8'h4B);

        // R8: slave receive->transmit event
        bus_read(2'd2, rd);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, rd); check("R9 cleared before slave event", rd & 8'h80, 8'h00);
        @(negedge clk); slave_tx_evt = 1'b1;
        @(negedge clk); slave_tx_evt = 1'b0;
        dut_tx = 1'b1;
        bus_read(2'd2, rd); check("R8 slave event sets flag", rd & 8'h80, 8'h80);
        bus_read(2'd1, rd); check("R8 slave event sets tx select", rd & 8'h01, 8'h01);

        // R11: stop releases clock
        ready = 1'b0;
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        @(negedge clk);
        check("R11 stop releases scl", {7'd0, scl_o}, 8'h01);
        check("R2 all expected bytes seen", 8'(exp_q.size()), 8'h00);

        summary();
        $finish;
    end

endmodule